// File: doc/BRIEF.md
# Black-Level Offset Feedback Controller

This block closes the digital half of a black-level clamp loop in an image-sensor front end. Each line carries an optical-black pulse. When that pulse turns active, the block opens a sampling window at a fixed clock offset and adds up eight converted black samples. It then divides the sum by eight and subtracts the result from a programmable clamp target. The signed difference becomes a correction step for an external current DAC. A new step is produced once per line and is announced by a one-clock strobe.

The loop normally runs at unity gain. Whenever the amplifier gain setting changes, a strobe puts the block into a lead-in mode. In that mode each step is shifted left by a selectable amount, which gives a gain of 2, 4, 8 or 16. Lead-in stays active while the line error is larger than 64 LSB. Once the error has stayed small for a selectable number of consecutive lines, unity gain returns. Steps are saturated to the signed output width.

Top module: `ob_offset_loop`

## Requirements
- R1: While rst_n is low, and after it is released, corr_o is 0, corr_vld_o is 0 and lead_o is 0.
- R2: The pulse is active when ob_i XOR ob_inv_i is 1. A window starts on the first clock edge at which the active level is seen after an inactive one.
- R3: If the start edge is edge 0, smp_i is summed at edges 5 through 12, which is 8 samples. Any new start edge seen while a window is open is ignored.
- R4: corr_vld_o is high for exactly one clock, right after edge 12 of the window. corr_o changes only at that edge and holds its value otherwise.
- R5: The target is 56 + 8*clamp_code_i LSB, for example 56, 128 or 304 for codes 0, 9 and 31. The error is the target minus (sum >> 3), taken as a signed value.
- R6: When lead-in is not active at the end of a window, corr_o equals the error.
- R7: A high gain_chg_i at a clock edge sets lead_o from the next cycle. During lead-in, corr_o is the error shifted left by mult_sel_i+1, so select values 0, 1, 2 and 3 give gains of 2, 4, 8 and 16.
- R8: A lead-in window whose error magnitude is 64 or less counts as a quiet line. A window with magnitude above 64 clears the count. After 2^hold_sel_i consecutive quiet lines (1, 2, 4 or 8), lead_o falls at the end of that window.
- R9: corr_o saturates to the signed CORR_W range, which is -32768 to 32767 by default.
- R10: If gain_chg_i is high at the closing edge of a window, that window's step still uses the gain in force before the edge. Lead-in is then set and the quiet count is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_i | input | 12 | ADC sample, one per clock |
| ob_i | input | 1 | Optical-black pulse |
| ob_inv_i | input | 1 | Pulse polarity invert |
| clamp_code_i | input | 5 | Clamp target code |
| gain_chg_i | input | 1 | Gain-change strobe |
| mult_sel_i | input | 2 | Lead-in gain select |
| hold_sel_i | input | 2 | Quiet-line count select |
| corr_o | output | 16 | Signed correction step |
| corr_vld_o | output | 1 | New step strobe |
| lead_o | output | 1 | Lead-in mode active |

## Verification
The assertions check on every cycle that the strobe lasts a single clock and that the step changes only with the strobe. They also check that an open window advances one edge per clock whatever the pulse does, that a gain strobe always raises lead_o, that lead-in ends only at a window close, and that the quiet count stays zero outside lead-in. The arithmetic can only be shown by the bench's line scenarios. This covers the target formula, the averaging, the shift amounts and saturation, the exact 64/65 threshold, the quiet-line count and its restart, and the priority of a gain strobe at a window's closing edge.

// File: rtl/ob_offset_loop.sv
module ob_offset_loop #(
  parameter int SMP_W      = 12,
  parameter int CODE_W     = 5,
  parameter int CORR_W     = 16,
  parameter int WIN_START  = 5,
  parameter int WIN_LEN    = 8,
  parameter int CLAMP_BASE = 56,
  parameter int CLAMP_STEP = 8,
  parameter int ERR_LIMIT  = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SMP_W-1:0]         smp_i,
  input  logic                     ob_i,
  input  logic                     ob_inv_i,
  input  logic [CODE_W-1:0]        clamp_code_i,
  input  logic                     gain_chg_i,
  input  logic [1:0]               mult_sel_i,
  input  logic [1:0]               hold_sel_i,
  output logic signed [CORR_W-1:0] corr_o,
  output logic                     corr_vld_o,
  output logic                     lead_o
);
  localparam int WIN_END = WIN_START + WIN_LEN - 1;
  localparam int CNT_W   = $clog2(WIN_END + 1);
  localparam int AVG_SH  = $clog2(WIN_LEN);
  localparam int SUM_W   = SMP_W + AVG_SH;
  localparam int ERR_W   = SMP_W + 1;
  localparam int WIDE_W  = ERR_W + 5;
  localparam logic signed [WIDE_W-1:0] SAT_HI = WIDE_W'((64'd1 << (CORR_W - 1)) - 64'd1);
  localparam logic signed [WIDE_W-1:0] SAT_LO = ~SAT_HI;

  logic             ob_q;
  logic [CNT_W-1:0] cnt;
  logic [SUM_W-1:0] acc;
  logic [3:0]       hold_cnt;

  wire ob_act  = ob_i ^ ob_inv_i;
  wire ob_rise = ob_act & ~ob_q;
  wire in_win  = (cnt >= CNT_W'(WIN_START)) && (cnt <= CNT_W'(WIN_END));
  wire last    = (cnt == CNT_W'(WIN_END));

  wire [SUM_W-1:0] sum_fin = acc + SUM_W'(smp_i);
  wire [SMP_W-1:0] avg     = SMP_W'(sum_fin >> AVG_SH);
  wire [SMP_W-1:0] target  = SMP_W'(CLAMP_BASE) + SMP_W'(clamp_code_i) * SMP_W'(CLAMP_STEP);

  wire signed [ERR_W-1:0]  err  = $signed({1'b0, target}) - $signed({1'b0, avg});
  wire        [ERR_W-1:0]  mag  = err[ERR_W-1] ? ERR_W'(-err) : ERR_W'(err);
  wire                     big  = mag > ERR_W'(ERR_LIMIT);
  wire signed [WIDE_W-1:0] errw = {{(WIDE_W-ERR_W){err[ERR_W-1]}}, err};
  wire [2:0]               shamt = {1'b0, mult_sel_i} + 3'd1;
  wire signed [WIDE_W-1:0] scaled = lead_o ? (errw <<< shamt) : errw;

  wire [CORR_W-1:0] corr_next =
      (scaled > SAT_HI) ? SAT_HI[CORR_W-1:0] :
      (scaled < SAT_LO) ? SAT_LO[CORR_W-1:0] :
                          scaled[CORR_W-1:0];

  wire [3:0] hold_need = 4'd1 << hold_sel_i;
  wire [3:0] hold_inc  = hold_cnt + 4'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ob_q       <= 1'b0;
      cnt        <= '0;
      acc        <= '0;
      corr_o     <= '0;
      corr_vld_o <= 1'b0;
      lead_o     <= 1'b0;
      hold_cnt   <= '0;
    end else begin
      ob_q       <= ob_act;
      corr_vld_o <= 1'b0;

      if (cnt == '0) begin
        acc <= '0;
        if (ob_rise) cnt <= CNT_W'(1);
      end else begin
        if (in_win) acc <= sum_fin;
        cnt <= last ? '0 : cnt + CNT_W'(1);
      end

      if (last) begin
        corr_o     <= corr_next;
        corr_vld_o <= 1'b1;
        if (lead_o) begin
          if (big) hold_cnt <= '0;
          else if (hold_inc >= hold_need) begin
            lead_o   <= 1'b0;
            hold_cnt <= '0;
          end else hold_cnt <= hold_inc;
        end
      end

      if (gain_chg_i) begin
        lead_o   <= 1'b1;
        hold_cnt <= '0;
      end
    end
  end

  assert_vld_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    corr_vld_o |=> !corr_vld_o);

  assert_corr_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !corr_vld_o |-> $stable(corr_o));

  assert_win_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && !last) |=> cnt == CNT_W'($past(cnt) + CNT_W'(1)));

  assert_lead_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gain_chg_i |=> lead_o);

  assert_exit_at_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lead_o) |-> corr_vld_o);

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !lead_o |-> hold_cnt == '0);
endmodule

// File: tb/ob_offset_loop_test.sv
`timescale 1ns/1ps
module ob_offset_loop_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] smp_i = '0;
  logic        ob_i = 1'b0;
  logic        ob_inv_i = 1'b0;
  logic [4:0]  clamp_code_i = '0;
  logic        gain_chg_i = 1'b0;
  logic [1:0]  mult_sel_i = '0;
  logic [1:0]  hold_sel_i = '0;
  logic signed [15:0] corr_o;
  logic        corr_vld_o;
  logic        lead_o;

  int checks = 0;
  int errors = 0;
  bit m_lead = 0;
  int m_hold = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ob_offset_loop uut (
    .clk(clk), .rst_n(rst_n), .smp_i(smp_i), .ob_i(ob_i), .ob_inv_i(ob_inv_i),
    .clamp_code_i(clamp_code_i), .gain_chg_i(gain_chg_i), .mult_sel_i(mult_sel_i),
    .hold_sel_i(hold_sel_i), .corr_o(corr_o), .corr_vld_o(corr_vld_o), .lead_o(lead_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sat16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // One line: pulse, window samples, close. lo/hi bound the random samples.
  task automatic do_line(input int code, input int lo, input int hi, input bit inv,
                         input bit retrig, input bit gc_at_close, input string req);
    int sum = 0;
    int err, mag, expc;
    logic act;
    @(negedge clk);
    ob_inv_i = inv; clamp_code_i = 5'(code);
    ob_i = ~inv;
    smp_i = 12'(lo + $urandom_range(hi - lo));
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      act = (k <= 2) || (retrig && k >= 6 && k <= 8);
      ob_i = act ^ inv;
      smp_i = 12'(lo + $urandom_range(hi - lo));
      if (k >= 5) sum += int'(smp_i);
      gain_chg_i = gc_at_close && (k == 12);
    end
    @(negedge clk);
    gain_chg_i = 1'b0;
    err  = 56 + 8 * code - sum / 8;
    mag  = err < 0 ? -err : err;
    expc = sat16(m_lead ? err * (1 << (int'(mult_sel_i) + 1)) : err);
    chk(corr_vld_o == 1'b1, {req, " vld R4"}, corr_vld_o, 1);
    chk(int'(corr_o) == expc, {req, " corr"}, corr_o, expc);
    if (m_lead) begin
      if (mag > 64) m_hold = 0;
      else begin
        m_hold++;
        if (m_hold >= (1 << int'(hold_sel_i))) begin m_lead = 0; m_hold = 0; end
      end
    end
    if (gc_at_close) begin m_lead = 1; m_hold = 0; end
    chk(lead_o == m_lead, {req, " lead R8"}, lead_o, m_lead);
    @(negedge clk);
    chk(corr_vld_o == 1'b0, "R4 pulse ends", corr_vld_o, 0);
    chk(int'(corr_o) == expc, "R4 corr held", corr_o, expc);
  endtask

  task automatic gain_change(input int msel);
    @(negedge clk);
    mult_sel_i = 2'(msel);
    gain_chg_i = 1'b1;
    @(negedge clk);
    gain_chg_i = 1'b0;
    m_lead = 1; m_hold = 0;
    chk(lead_o == 1'b1, "R7 lead entry", lead_o, 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(corr_o == 0, "R1 corr reset", corr_o, 0);
    chk(corr_vld_o == 0, "R1 vld reset", corr_vld_o, 0);
    chk(lead_o == 0, "R1 lead reset", lead_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(corr_vld_o == 0 && lead_o == 0, "R1 after release", corr_vld_o, 0);

    do_line(9, 128, 128, 0, 0, 0, "R5 code9 zero error");
    do_line(31, 100, 100, 0, 0, 0, "R6 code31");
    do_line(0, 4095, 4095, 0, 0, 0, "R6 code0 negative");
    do_line(9, 120, 140, 1, 0, 0, "R2 inverted pulse");
    do_line(12, 0, 400, 0, 1, 0, "R3 retrigger ignored");
    repeat (20) @(negedge clk);
    chk(corr_vld_o == 0, "R3 no second window", corr_vld_o, 0);

    gain_change(3);
    do_line(0, 4095, 4095, 0, 0, 0, "R9 low saturation");
    do_line(31, 0, 0, 0, 0, 0, "R7 x16");
    mult_sel_i = 2'd0;
    do_line(31, 0, 0, 0, 0, 0, "R7 x2");

    hold_sel_i = 2'd2;
    do_line(9, 64, 64, 0, 0, 0, "R8 err 64 quiet");
    do_line(9, 128, 128, 0, 0, 0, "R8 quiet 2");
    do_line(9, 63, 63, 0, 0, 0, "R8 err 65 restart");
    for (int i = 0; i < 4; i++) do_line(9, 100, 150, 0, 0, 0, "R8 count out");
    chk(lead_o == 1'b0, "R8 lead cleared", lead_o, 0);

    mult_sel_i = 2'd1; hold_sel_i = 2'd0;
    do_line(9, 128, 128, 0, 0, 1, "R10 gain at close");
    chk(lead_o == 1'b1, "R10 lead set", lead_o, 1);
    do_line(9, 60, 60, 0, 0, 0, "R8 one line hold");

    for (int i = 0; i < 60; i++) begin
      int lo = $urandom_range(4000);
      mult_sel_i = 2'($urandom_range(3));
      hold_sel_i = 2'($urandom_range(3));
      if ($urandom_range(5) == 0) gain_change(int'(mult_sel_i));
      do_line($urandom_range(31), lo, lo + $urandom_range(95), $urandom_range(1),
              $urandom_range(3) == 0, $urandom_range(9) == 0, "R6 random line");
      repeat ($urandom_range(4)) @(negedge clk);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule